// File: doc/BRIEF.md
# Fetch Address and Stall Controller

This block sits at the front of an out-of-order core. Each cycle it sees the instruction word held at the current fetch address. It decides whether that instruction may be handed to the scheduling tables, and it picks the address to fetch next. Four separate conditions can make the instruction wait. While it waits, the fetch address and the tag counter stay put, so the same instruction tries to dispatch again on the next cycle. The four conditions are an instruction-side miss, a jump whose target register still has a write outstanding, a second conditional branch while an earlier prediction is unresolved, and a full scheduling table.

Jumps and unconditional branches are resolved here. Conditional branches follow the supplied prediction. Every dispatched conditional branch gets a checkpoint save strobe. When the execution side reports that a prediction was wrong, fetch is steered to the corrected address and a repair strobe follows. An interrupt sends fetch to a fixed vector. Dispatched instructions receive tags from a counter that wraps.

Top module: `fetch_ctrl`

## Requirements
- R1: After synchronous reset the outputs are as follows. `fetch_pc` equals RESET_PC, `inst_tag` is 0, and `ckpt_save` and `repair` are 0. No branch counts as unresolved.
- R2: A valid instruction with `icache_miss` or `itlb_miss` high does not dispatch, and `stall_cause` reads 1.
- R3: Take a valid jump (`is_jump`) while `r31_busy` is high. It does not dispatch, and `stall_cause` reads 2 unless a fetch miss is also present. Once it dispatches, the next `fetch_pc` equals `r31_value`.
- R4: A valid conditional branch (`is_cond`) does not dispatch while an earlier dispatched conditional branch has no `verify_valid` yet. In that case `stall_cause` reads 3 unless a higher cause is present. Once the verify pulse has arrived, a further conditional branch may dispatch.
- R5: A valid instruction with `nt_full` high does not dispatch. `stall_cause` reads 4 when no other cause is present.
- R6: When several causes are present, `stall_cause` reports the highest one. The order from highest down is fetch miss (1), jump pending (2), double branch (3), table full (4). The value 0 means no stall.
- R7: Suppose a cycle does not dispatch and has neither a misprediction nor an interrupt. Then `fetch_pc` and `inst_tag` are unchanged in the next cycle.
- R8: A dispatched plain instruction, or a conditional branch predicted not taken, gives next `fetch_pc` = `fetch_pc`+1. An unconditional branch (`is_ubr`), or a conditional branch with `pred_taken`, gives `fetch_pc`+`br_offset`. The offset is two's complement, and the sum wraps modulo 2^PC_W.
- R9: `inst_tag` advances by one for each dispatched instruction and wraps from 2^TAG_W-1 to 0.
- R10: `ckpt_save` is high in the cycle after a conditional branch dispatches, and at no other time.
- R11: When `verify_valid` and `verify_wrong` are both high, the current instruction does not dispatch. The next `fetch_pc` equals `fix_pc`, `repair` is high for the following cycle, and no branch counts as unresolved afterwards.
- R12: With `irq` high and no misprediction, the current instruction does not dispatch and the next `fetch_pc` equals IRQ_VEC. A misprediction outranks an interrupt.
- R13: `dispatch_en` is high exactly when all of the following hold: `inst_valid` is high, `stall_cause` is 0, there is no misprediction, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Instruction at `fetch_pc` is present |
| icache_miss | input | 1 | Instruction cache miss |
| itlb_miss | input | 1 | Instruction translation miss |
| r31_busy | input | 1 | Write to the jump target register outstanding |
| nt_full | input | 1 | A scheduling table has no free entry |
| is_jump | input | 1 | Instruction is a register-target jump |
| is_ubr | input | 1 | Instruction is an unconditional relative branch |
| is_cond | input | 1 | Instruction is a conditional branch |
| pred_taken | input | 1 | Prediction for the conditional branch |
| br_offset | input | PC_W | Signed branch displacement |
| r31_value | input | PC_W | Jump target register contents |
| verify_valid | input | 1 | Outstanding prediction resolved this cycle |
| verify_wrong | input | 1 | Resolved prediction was wrong |
| fix_pc | input | PC_W | Corrected fetch address after a wrong prediction |
| irq | input | 1 | Interrupt request |
| fetch_pc | output | PC_W | Current fetch address |
| dispatch_en | output | 1 | Current instruction dispatches this cycle |
| stall_cause | output | 3 | Highest active stall cause (0 none) |
| inst_tag | output | TAG_W | Tag given to the dispatching instruction |
| ckpt_save | output | 1 | Checkpoint save strobe |
| repair | output | 1 | State repair strobe |

## Verification
The bench runs a complete sweep over every mix of the four stall inputs. The sweep covers the four instruction kinds, both with and without an unresolved branch. This separates the priority order from the mere presence of a stall, and it shows that a double branch only counts for conditional branches. An offset sweep with positive, negative and wrapping displacements, and with both prediction values, separates the sequential path from the relative path. Mispredictions and interrupts are placed together with stalls and with each other to confirm the order of the redirects. A long pseudorandom stretch then checks dispatch, addresses, tags and strobes against the bench's own model on every cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [2:0] {
    STALL_NONE  = 3'd0,
    STALL_FETCH = 3'd1,
    STALL_JUMP  = 3'd2,
    STALL_DBLBR = 3'd3,
    STALL_OVFL  = 3'd4
  } stall_e;

  localparam int unsigned NUM_CAUSES = 4;
endpackage

// File: rtl/fc_stall_arb.sv
module fc_stall_arb
  import fc_pkg::*;
(
  input  logic   inst_valid,
  input  logic   miss_any,
  input  logic   r31_busy,
  input  logic   is_jump,
  input  logic   is_cond,
  input  logic   br_unverified,
  input  logic   nt_full,
  output stall_e cause
);
  // request bit i maps to cause code i+1; lower index wins
  logic [NUM_CAUSES-1:0] req;

  assign req[0] = inst_valid && miss_any;
  assign req[1] = inst_valid && is_jump && r31_busy;
  assign req[2] = inst_valid && is_cond && br_unverified;
  assign req[3] = inst_valid && nt_full;

  always_comb begin
    cause = STALL_NONE;
    for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
      if (req[i]) cause = stall_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/fc_pc_sel.sv
module fc_pc_sel #(
  parameter int unsigned PC_W    = 16,
  parameter logic [PC_W-1:0] IRQ_VEC = '1
) (
  input  logic [PC_W-1:0] cur_pc,
  input  logic            redirect,
  input  logic [PC_W-1:0] fix_pc,
  input  logic            irq,
  input  logic            dispatch,
  input  logic            is_jump,
  input  logic            is_ubr,
  input  logic            is_cond,
  input  logic            pred_taken,
  input  logic [PC_W-1:0] offset,
  input  logic [PC_W-1:0] r31_value,
  output logic [PC_W-1:0] next_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_pc;
  logic            take_rel;

  assign seq_pc   = cur_pc + STEP;
  assign rel_pc   = cur_pc + offset;
  assign take_rel = is_ubr || (is_cond && pred_taken);

  // six sources: repair target, vector, hold, register target, relative, sequential
  always_comb begin
    if (redirect)      next_pc = fix_pc;
    else if (irq)      next_pc = IRQ_VEC;
    else if (!dispatch) next_pc = cur_pc;
    else if (is_jump)  next_pc = r31_value;
    else if (take_rel) next_pc = rel_pc;
    else               next_pc = seq_pc;
  end
endmodule

// File: rtl/fc_tag_ctr.sv
module fc_tag_ctr #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (rst)      tag <= '0;
    else if (adv) tag <= tag + TAG_W'(1);
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fc_pkg::*;
#(
  parameter int unsigned     PC_W     = 16,
  parameter int unsigned     TAG_W    = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inst_valid,
  input  logic             icache_miss,
  input  logic             itlb_miss,
  input  logic             r31_busy,
  input  logic             nt_full,
  input  logic             is_jump,
  input  logic             is_ubr,
  input  logic             is_cond,
  input  logic             pred_taken,
  input  logic [PC_W-1:0]  br_offset,
  input  logic [PC_W-1:0]  r31_value,
  input  logic             verify_valid,
  input  logic             verify_wrong,
  input  logic [PC_W-1:0]  fix_pc,
  input  logic             irq,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             dispatch_en,
  output logic [2:0]       stall_cause,
  output logic [TAG_W-1:0] inst_tag,
  output logic             ckpt_save,
  output logic             repair
);
  stall_e          cause;
  logic            br_unverified;
  logic            mispredict;
  logic [PC_W-1:0] next_pc;

  assign mispredict = verify_valid && verify_wrong;

  fc_stall_arb u_arb (
    .inst_valid    (inst_valid),
    .miss_any      (icache_miss || itlb_miss),
    .r31_busy      (r31_busy),
    .is_jump       (is_jump),
    .is_cond       (is_cond),
    .br_unverified (br_unverified),
    .nt_full       (nt_full),
    .cause         (cause)
  );

  assign stall_cause = 3'(cause);
  assign dispatch_en = inst_valid && (cause == STALL_NONE) && !mispredict && !irq;

  fc_pc_sel #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_pc_sel (
    .cur_pc     (fetch_pc),
    .redirect   (mispredict),
    .fix_pc     (fix_pc),
    .irq        (irq),
    .dispatch   (dispatch_en),
    .is_jump    (is_jump),
    .is_ubr     (is_ubr),
    .is_cond    (is_cond),
    .pred_taken (pred_taken),
    .offset     (br_offset),
    .r31_value  (r31_value),
    .next_pc    (next_pc)
  );

  fc_tag_ctr #(.TAG_W(TAG_W)) u_tag (
    .clk (clk),
    .rst (rst),
    .adv (dispatch_en),
    .tag (inst_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc      <= RESET_PC;
      br_unverified <= 1'b0;
      ckpt_save     <= 1'b0;
      repair        <= 1'b0;
    end else begin
      fetch_pc  <= next_pc;
      ckpt_save <= dispatch_en && is_cond;
      repair    <= mispredict;
      if (mispredict)                 br_unverified <= 1'b0;
      else if (dispatch_en && is_cond) br_unverified <= 1'b1;
      else if (verify_valid)          br_unverified <= 1'b0;
    end
  end
endmodule

// File: rtl/fetch_ctrl_chk.sv
module fetch_ctrl_chk #(
  parameter int unsigned     PC_W    = 16,
  parameter int unsigned     TAG_W   = 4,
  parameter logic [PC_W-1:0] IRQ_VEC = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             inst_valid,
  input logic             icache_miss,
  input logic             itlb_miss,
  input logic             r31_busy,
  input logic             nt_full,
  input logic             is_jump,
  input logic             is_cond,
  input logic             verify_valid,
  input logic             verify_wrong,
  input logic [PC_W-1:0]  fix_pc,
  input logic             irq,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             dispatch_en,
  input logic [2:0]       stall_cause,
  input logic [TAG_W-1:0] inst_tag,
  input logic             ckpt_save,
  input logic             repair
);
  AST_FETCH_MISS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    inst_valid && (icache_miss || itlb_miss) |-> stall_cause == 3'd1); // R2
  AST_JUMP_WAIT: assert property (@(posedge clk) disable iff (rst)
    inst_valid && is_jump && r31_busy && !icache_miss && !itlb_miss |-> stall_cause == 3'd2); // R3
  AST_TABLE_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    inst_valid && nt_full |-> !dispatch_en); // R5
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    stall_cause != 3'd0 |-> !dispatch_en); // R6
  AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
    !dispatch_en && !irq && !(verify_valid && verify_wrong) |=> $stable(fetch_pc)); // R7
  AST_HOLD_TAG: assert property (@(posedge clk) disable iff (rst)
    !dispatch_en |=> $stable(inst_tag)); // R7
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
    dispatch_en |=> inst_tag == TAG_W'($past(inst_tag) + 1'b1)); // R9
  AST_SAVE_ON_COND: assert property (@(posedge clk) disable iff (rst)
    dispatch_en && is_cond |=> ckpt_save); // R10
  AST_REPAIR_PULSE: assert property (@(posedge clk) disable iff (rst)
    verify_valid && verify_wrong |=> repair && fetch_pc == $past(fix_pc)); // R11
  AST_MISP_SQUASH: assert property (@(posedge clk) disable iff (rst)
    verify_valid && verify_wrong |-> !dispatch_en); // R11
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
    irq && !(verify_valid && verify_wrong) |=> fetch_pc == IRQ_VEC); // R12
endmodule

bind fetch_ctrl fetch_ctrl_chk #(.PC_W(PC_W), .TAG_W(TAG_W), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .inst_valid   (inst_valid),
  .icache_miss  (icache_miss),
  .itlb_miss    (itlb_miss),
  .r31_busy     (r31_busy),
  .nt_full      (nt_full),
  .is_jump      (is_jump),
  .is_cond      (is_cond),
  .verify_valid (verify_valid),
  .verify_wrong (verify_wrong),
  .fix_pc       (fix_pc),
  .irq          (irq),
  .fetch_pc     (fetch_pc),
  .dispatch_en  (dispatch_en),
  .stall_cause  (stall_cause),
  .inst_tag     (inst_tag),
  .ckpt_save    (ckpt_save),
  .repair       (repair)
);

// File: tb/fetch_ctrl_tb.sv
module fetch_ctrl_tb;
  localparam int unsigned     PC_W  = 8;
  localparam int unsigned     TAG_W = 3;
  localparam logic [PC_W-1:0] RPC   = 8'h10;
  localparam logic [PC_W-1:0] IVEC  = 8'hE0;

  logic clk = 1'b0;
  logic rst;
  logic iv, icm, tlm, r31b, ntf, jmp, ubr, cnd, pt, vv, vw, irq;
  logic [PC_W-1:0] off, r31v, fpc;
  logic [PC_W-1:0] pc;
  logic dis, save, rep;
  logic [2:0] cause;
  logic [TAG_W-1:0] tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [PC_W-1:0]  m_pc;
  logic [TAG_W-1:0] m_tag;
  logic             m_pend;
  string            pc_req;

  always #4 clk = ~clk;

  fetch_ctrl #(.PC_W(PC_W), .TAG_W(TAG_W), .RESET_PC(RPC), .IRQ_VEC(IVEC)) u_dut (
    .clk(clk), .rst(rst), .inst_valid(iv), .icache_miss(icm), .itlb_miss(tlm),
    .r31_busy(r31b), .nt_full(ntf), .is_jump(jmp), .is_ubr(ubr), .is_cond(cnd),
    .pred_taken(pt), .br_offset(off), .r31_value(r31v), .verify_valid(vv),
    .verify_wrong(vw), .fix_pc(fpc), .irq(irq), .fetch_pc(pc), .dispatch_en(dis),
    .stall_cause(cause), .inst_tag(tag), .ckpt_save(save), .repair(rep)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    {iv, icm, tlm, r31b, ntf, jmp, ubr, cnd, pt, vv, vw, irq} = '0;
    off = '0; r31v = '0; fpc = '0;
  endtask

  // one cycle: inputs already driven at a falling edge
  task automatic run_cycle();
    logic h, jp, db, ov, misp, ed;
    int ec;
    string creq;
    #1;
    h  = iv && (icm || tlm);
    jp = iv && jmp && r31b;
    db = iv && cnd && m_pend;
    ov = iv && ntf;
    ec = h ? 1 : jp ? 2 : db ? 3 : ov ? 4 : 0;
    misp = vv && vw;
    ed = iv && ec == 0 && !misp && !irq;
    creq = (int'(h) + int'(jp) + int'(db) + int'(ov) > 1) ? "R6" :
           ec == 1 ? "R2" : ec == 2 ? "R3" : ec == 3 ? "R4" : ec == 4 ? "R5" : "R6";
    check(creq, int'(cause), ec);
    check("R13", int'(dis), int'(ed));
    check(pc_req, int'(pc), int'(m_pc));
    check("R9", int'(tag), int'(m_tag));
    if (misp)          begin m_pc = fpc;  pc_req = "R11"; end
    else if (irq)      begin m_pc = IVEC; pc_req = "R12"; end
    else if (!ed)      begin pc_req = "R7"; end
    else if (jmp)      begin m_pc = r31v; pc_req = "R3"; end
    else if (ubr || (cnd && pt)) begin m_pc = m_pc + off; pc_req = "R8"; end
    else               begin m_pc = m_pc + 8'd1; pc_req = "R8"; end
    if (ed) m_tag = m_tag + 3'd1;
    if (misp)          m_pend = 1'b0;
    else if (ed && cnd) m_pend = 1'b1;
    else if (vv)       m_pend = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10", int'(save), int'(ed && cnd));
    check("R11", int'(rep), int'(misp));
  endtask

  task automatic set_pending(input bit want);
    if (want && !m_pend) begin
      clear_in(); iv = 1; cnd = 1; run_cycle();
    end else if (!want && m_pend) begin
      clear_in(); vv = 1; run_cycle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1;
    m_pc = RPC; m_tag = '0; m_pend = 1'b0; pc_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", int'(pc), int'(RPC));
    check("R1", int'(tag), 0);
    check("R1", int'(save), 0);
    check("R1", int'(rep), 0);
    // R1: no unresolved branch, so a conditional branch dispatches at once
    clear_in(); iv = 1; cnd = 1; run_cycle();
    clear_in(); vv = 1; run_cycle();

    // exhaustive stall sweep: causes x instruction kind x pending
    for (int k = 0; k < 128; k++) begin
      set_pending(k[6]);
      clear_in();
      iv = 1;
      {icm, tlm, r31b, ntf} = k[3:0];
      case (k[5:4])
        2'd1: begin jmp = 1; r31v = 8'(k * 3); end
        2'd2: begin cnd = 1; pt = k[0]; off = 8'(k); end
        2'd3: begin ubr = 1; off = 8'(256 - k); end
        default: ;
      endcase
      run_cycle();
    end
    set_pending(1'b0);

    // offset sweep, wrap in both directions (R8)
    for (int k = 0; k < 64; k++) begin
      clear_in(); iv = 1; off = 8'(k * 37 + 200);
      if (k[0]) ubr = 1; else begin cnd = 1; pt = k[1]; end
      run_cycle();
      set_pending(1'b0);
    end

    // R4: second conditional waits, dispatches after verify
    set_pending(1'b1);
    clear_in(); iv = 1; cnd = 1; run_cycle();
    clear_in(); iv = 1; cnd = 1; vv = 1; run_cycle();
    clear_in(); iv = 1; cnd = 1; run_cycle();
    // R11: misprediction with a stall and an interrupt present
    clear_in(); iv = 1; ntf = 1; irq = 1; vv = 1; vw = 1; fpc = 8'h5A; run_cycle();
    clear_in(); iv = 1; cnd = 1; run_cycle();
    // R12: interrupt alone, then with a stall
    clear_in(); iv = 1; irq = 1; vv = 1; run_cycle();
    clear_in(); iv = 1; icm = 1; irq = 1; run_cycle();
    // R3: jump released
    clear_in(); iv = 1; jmp = 1; r31b = 1; r31v = 8'h33; run_cycle();
    clear_in(); iv = 1; jmp = 1; r31v = 8'h33; run_cycle();

    // pseudorandom stretch
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom);
      clear_in();
      iv = r[0] | r[1]; icm = r[2] & r[3]; tlm = r[4] & r[5] & r[6];
      r31b = r[7]; ntf = r[8] & r[9];
      case (r[11:10])
        2'd1: jmp = 1;
        2'd2: cnd = 1;
        2'd3: ubr = 1;
        default: ;
      endcase
      pt = r[12]; off = r[20:13]; r31v = r[28:21];
      vv = r[29] & r[30]; vw = r[31] & r[2]; fpc = r[27:20];
      irq = (r[5:0] == 6'd9);
      run_cycle();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule